// File: doc/BRIEF.md
# Geometry Coprocessor Register File

This block holds the architectural registers of a 3D geometry coprocessor. There are 64 words of 32 bits in one flat index space. Indices 0 to 31 are the data registers. Indices 32 to 63 are the control registers: a control access with selector n uses index n+32. The block has one synchronous write port, with an enable, an index and data. It has one combinational read port, with an index and data.

Many indices are more than plain storage. A write can narrow its data to a signed or unsigned 16-bit value. A write can push a three-deep screen-coordinate queue, or spread a packed 5:5:5 colour over three intermediate registers. A write can mask a status word and derive its summary bit, or count leading sign bits. Some reads return a mirror of another register or a value computed from other registers. The host drives one access per cycle through these ports.

Top module: `gcop_regfile`

## Requirements
- R1: After reset, every index from 0 to 63 reads as zero.
- R2: A write to data index 1, 3, 5, 8, 9, 10 or 11 stores bits 15:0 of the data, with bit 15 copied into bits 31:16.
- R3: A write to control index 36, 44, 52, 58, 59, 61 or 62 stores bits 15:0 of the data, with bit 15 copied into bits 31:16.
- R4: A write to index 7, 16, 17, 18 or 19 stores bits 15:0 of the data, with bits 31:16 cleared.
- R5: A write to index 15 shifts the queue in a single edge: index 12 gets the old value of index 13, index 13 gets the old value of index 14, and index 14 gets the written word.
- R6: A read of index 15 returns the current contents of index 14.
- R7: A write to index 28 sets index 9 to data[4:0]*128, index 10 to data[9:5]*128 and index 11 to data[14:10]*128.
- R8: A read of index 28 or 29 returns the packed colour {17'b0, c11, c10, c9}. Each 5-bit cN is the signed contents of index N shifted arithmetically right by 7 and clamped to the range 0 to 31. Here c9 lands in bits 4:0, c10 in bits 9:5 and c11 in bits 14:10.
- R9: Writes to index 29 and to index 31 change no register.
- R10: A write to index 63 keeps data bits 30:12 and clears bits 11:0. Bit 31 is then set to the OR of the stored bits 30:23 and 18:13.
- R11: A write to index 30 stores the word unchanged. It also sets index 31 to the number of leading bits that equal bit 31, a value from 1 to 32.
- R12: A write to any index not named above stores the full 32-bit word unchanged. This includes indices 0, 2, 4, 6, 12 to 14, 20 to 27 and the remaining control indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index (control selector n is index n+32) |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Read index |
| rd_data | output | 32 | Read data, combinational |

## Verification
The in-line assertions check the following on every cycle: the queue shift, the index-15 mirror, the narrowing of the extended indices, the status-word invariants, the range of the colour read and that index 31 stays put under its own write. Only the bench scenarios show some other properties. These are the numeric colour unpack and clamp at both range ends, the leading-bit counts at the all-zero, all-one and single-transition edges, and that writes leave unrelated indices alone. A reference model checks them over long random access streams.

// File: rtl/gcop_regfile.sv
module gcop_regfile #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam int NREG = 1 << AW;
  localparam int CW   = $clog2(DW + 1);

  logic [DW-1:0] regs [NREG];

  function automatic logic [DW-1:0] sx16(input logic [DW-1:0] v);
    return {{(DW-16){v[15]}}, v[15:0]};
  endfunction

  function automatic logic [DW-1:0] zx16(input logic [DW-1:0] v);
    return {{(DW-16){1'b0}}, v[15:0]};
  endfunction

  function automatic logic [4:0] clamp5(input logic [DW-1:0] v);
    logic signed [DW-1:0] s;
    s = $signed(v) >>> 7;
    if (s < 0) return 5'd0;
    else if (s > 31) return 5'd31;
    else return s[4:0];
  endfunction

  function automatic logic [CW-1:0] lead_run(input logic [DW-1:0] v);
    logic [CW-1:0] n;
    logic          run;
    n   = 1;
    run = 1'b1;
    for (int k = DW - 2; k >= 0; k--) begin
      if (run && v[k] == v[DW-1]) n = n + 1'b1;
      else run = 1'b0;
    end
    return n;
  endfunction

  function automatic logic [DW-1:0] stat_fix(input logic [DW-1:0] v);
    logic [DW-1:0] m;
    m = v & 32'h7FFF_F000;
    m[31] = |m[30:23] | |m[18:13];
    return m;
  endfunction

  function automatic logic [DW-1:0] col_field(input logic [4:0] f);
    return sx16({{(DW-12){1'b0}}, f, 7'd0});
  endfunction

  logic [14:0] colour_rd;
  assign colour_rd = {clamp5(regs[11]), clamp5(regs[10]), clamp5(regs[9])};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        6'd1, 6'd3, 6'd5, 6'd8, 6'd9, 6'd10, 6'd11,
        6'd36, 6'd44, 6'd52, 6'd58, 6'd59, 6'd61, 6'd62:
          regs[wr_idx] <= sx16(wr_data);
        6'd7, 6'd16, 6'd17, 6'd18, 6'd19:
          regs[wr_idx] <= zx16(wr_data);
        6'd15: begin
          regs[12] <= regs[13];
          regs[13] <= regs[14];
          regs[14] <= wr_data;
        end
        6'd28: begin
          regs[9]  <= col_field(wr_data[4:0]);
          regs[10] <= col_field(wr_data[9:5]);
          regs[11] <= col_field(wr_data[14:10]);
        end
        6'd29, 6'd31: ;
        6'd30: begin
          regs[30] <= wr_data;
          regs[31] <= {{(DW-CW){1'b0}}, lead_run(wr_data)};
        end
        6'd63:
          regs[63] <= stat_fix(wr_data);
        default:
          regs[wr_idx] <= wr_data;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      6'd15:        rd_data = regs[14];
      6'd28, 6'd29: rd_data = {{(DW-15){1'b0}}, colour_rd};
      default:      rd_data = regs[rd_idx];
    endcase
  end

  // R5
  queue_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 6'd15) |=> (regs[12] == $past(regs[13]) &&
      regs[13] == $past(regs[14]) && regs[14] == $past(wr_data)));

  // R6
  mirror_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 6'd15) |-> (rd_data == regs[14]));

  // R2
  data_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 6'd1 || wr_idx == 6'd8)) |=>
      (regs[$past(wr_idx)] == {{16{$past(wr_data[15])}}, $past(wr_data[15:0])}));

  // R4
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= 6'd16 && wr_idx <= 6'd19) |=> (regs[$past(wr_idx)][31:16] == 16'd0));

  // R10
  stat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[63][11:0] == 12'd0) && (regs[63][31] == (|regs[63][30:23] || |regs[63][18:13])));

  // R8
  colour_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 6'd28 || rd_idx == 6'd29) |-> (rd_data[31:15] == 17'd0));

  // R9
  ro_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 6'd31) |=> $stable(regs[31]));

  // R11
  lead_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 6'd30) |=> (regs[31] >= 1 && regs[31] <= 32));
endmodule

// File: tb/gcop_regfile_tb.sv
`timescale 1ns/1ps
module gcop_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [64];

  always #2 clk = ~clk;

  gcop_regfile u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
                      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));

  function automatic logic [31:0] sx(input logic [31:0] v);
    return {{16{v[15]}}, v[15:0]};
  endfunction

  function automatic logic [4:0] cl(input logic [31:0] v);
    int s;
    s = $signed(v) >>> 7;
    return (s < 0) ? 5'd0 : (s > 31) ? 5'd31 : 5'(s);
  endfunction

  function automatic logic [31:0] lead(input logic [31:0] v);
    int n;
    n = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k] != v[31]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] m_read(input int i);
    if (i == 15) return m[14];
    if (i == 28 || i == 29) return {17'd0, cl(m[11]), cl(m[10]), cl(m[9])};
    return m[i];
  endfunction

  function automatic string tag(input int i);
    case (i)
      1, 3, 5, 8, 9, 10, 11: return "R2";
      36, 44, 52, 58, 59, 61, 62: return "R3";
      7, 16, 17, 18, 19: return "R4";
      15: return "R5/R6";
      28: return "R7/R8";
      29, 31: return "R9";
      30: return "R11";
      63: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic m_write(input int i, input logic [31:0] d);
    case (i)
      1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61, 62: m[i] = sx(d);
      7, 16, 17, 18, 19: m[i] = {16'd0, d[15:0]};
      15: begin m[12] = m[13]; m[13] = m[14]; m[14] = d; end
      28: begin
        m[9]  = {20'd0, d[4:0], 7'd0};
        m[10] = {20'd0, d[9:5], 7'd0};
        m[11] = {20'd0, d[14:10], 7'd0};
      end
      29, 31: ;
      30: begin m[30] = d; m[31] = lead(d); end
      63: begin
        m[63] = d & 32'h7FFF_F000;
        m[63][31] = |m[63][30:23] | |m[63][18:13];
      end
      default: m[i] = d;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_write(i, d);
  endtask

  task automatic rd_chk(input string req, input int i, input logic [31:0] exp);
    rd_idx = 6'(i);
    #0.5;
    check(req, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) rd_chk("R1", i, 32'd0);

    wr(1, 32'h1234_8001);  rd_chk("R2", 1, 32'hFFFF_8001);
    wr(8, 32'hABCD_7FFF);  rd_chk("R2", 8, 32'h0000_7FFF);
    wr(58, 32'h0000_9000); rd_chk("R3", 58, 32'hFFFF_9000);
    wr(62, 32'hFFFF_0042); rd_chk("R3", 62, 32'h0000_0042);
    wr(17, 32'hFFFF_FFFF); rd_chk("R4", 17, 32'h0000_FFFF);

    wr(15, 32'h0000_0011); wr(15, 32'h0000_0022); wr(15, 32'h0000_0033);
    rd_chk("R5", 12, 32'h11); rd_chk("R5", 13, 32'h22); rd_chk("R5", 14, 32'h33);
    rd_chk("R6", 15, 32'h33);
    wr(15, 32'hDEAD_BEEF);
    rd_chk("R5", 12, 32'h22); rd_chk("R6", 15, 32'hDEAD_BEEF);

    wr(28, 32'hFFFF_FFFF);
    rd_chk("R7", 9, 32'd3968); rd_chk("R7", 10, 32'd3968); rd_chk("R7", 11, 32'd3968);
    rd_chk("R8", 28, 32'h0000_7FFF);
    wr(28, 32'h0000_0C41);
    rd_chk("R7", 9, 32'd128); rd_chk("R7", 10, 32'd256); rd_chk("R7", 11, 32'd384);
    rd_chk("R8", 29, 32'h0000_0C41);
    wr(9, 32'h0000_8000); wr(10, 32'h0000_7FFF);
    rd_chk("R8", 28, {17'd0, 5'd3, 5'd31, 5'd0});
    wr(29, 32'h0000_0000);
    rd_chk("R9", 9, 32'hFFFF_8000); rd_chk("R9", 29, {17'd0, 5'd3, 5'd31, 5'd0});

    wr(30, 32'h0000_0000);  rd_chk("R11", 31, 32'd32); rd_chk("R11", 30, 32'd0);
    wr(30, 32'hFFFF_FFFF);  rd_chk("R11", 31, 32'd32);
    wr(30, 32'h4000_0000);  rd_chk("R11", 31, 32'd1);
    wr(30, 32'h8000_0000);  rd_chk("R11", 31, 32'd1);
    wr(30, 32'h0001_0000);  rd_chk("R11", 31, 32'd15);
    wr(31, 32'h0000_0007);  rd_chk("R9", 31, 32'd15);

    wr(63, 32'hFFFF_FFFF);  rd_chk("R10", 63, 32'hFFFF_F000);
    wr(63, 32'h0040_0FFF);  rd_chk("R10", 63, 32'h0040_0000);
    wr(63, 32'h0000_2000);  rd_chk("R10", 63, 32'h8000_2000);
    wr(63, 32'h0080_0000);  rd_chk("R10", 63, 32'h8080_0000);

    wr(0, 32'hCAFE_F00D);  rd_chk("R12", 0, 32'hCAFE_F00D);
    wr(40, 32'h8765_4321); rd_chk("R12", 40, 32'h8765_4321);

    for (int n = 0; n < 3000; n++) begin
      int i, j;
      logic [31:0] d;
      i = int'($urandom % 64);
      d = $urandom;
      if (n % 7 == 0) d = {{16{d[0]}}, d[15:0]};
      wr(i, d);
      rd_chk(tag(i), i, m_read(i));
      j = int'($urandom % 64);
      rd_chk(tag(j), j, m_read(j));
    end
    for (int i = 0; i < 64; i++) rd_chk(tag(i), i, m_read(i));

    finish_run();
  end
endmodule